// File: doc/BRIEF.md
# Dual-Mode Serial Shift and Event Count Register

This block holds a small data register that plays one of two roles, picked by a two-bit mode register. In shift mode the register moves one place toward its most significant bit on every instruction-cycle enable. The serial input fills the vacated low bit, and the serial output can present the top bit. In count mode the same register becomes a down counter. It loses one count for each falling edge on the serial input, provided the input then stays low for a minimum number of sampled instruction cycles.

A parallel exchange port lets the surrounding datapath swap its own value with the register contents in one instruction cycle. The same operation loads a clock-control latch from a carry bit. That latch gates the serial clock output: in shift mode it enables a copy of the instruction-cycle phase, and in count mode it drives the pin as a static level. The accumulator and the instruction decoding that issue the exchange sit outside the block.

Top module: `sio_dual_reg`

## Requirements
- R1: While reset is asserted and after its release, the data register reads 0, both mode bits read 0 (shift mode, output disabled), the clock-control latch reads 1, so_o is 0 and sk_o follows cyc_phase_i.
- R2: A cycle with mode_ld_i high loads mode_wdata_i into the mode register: bit 0 selects count mode (1) or shift mode (0), and bit 1 is the output-enable bit. The load does not wait for cyc_en_i.
- R3: In shift mode, each cycle with cyc_en_i high and no exchange replaces the register with its old value shifted left by one, with si_i in bit 0. Without cyc_en_i the register holds.
- R4: In shift mode, so_o equals the register MSB when the output-enable bit is 1 and is 0 when it is 0.
- R5: In count mode, so_o equals the output-enable bit.
- R6: The serial input is sampled on cycles with cyc_en_i high. A decrement is produced only after at least one high sample followed by LOW_SAMPLES (default 2) consecutive low samples, on the last of those samples. Fewer low samples before a high sample produce nothing, and a held low produces only one decrement.
- R7: In count mode the counter decrements by one per qualified pulse, and 0 wraps to all ones (15 for a 4-bit register).
- R8: sk_o equals the clock-control latch ANDed with cyc_phase_i in shift mode, and equals the latch alone in count mode.
- R9: An exchange (xchg_i high together with cyc_en_i) loads xchg_wdata_i into the register and carry_i into the clock-control latch. xchg_rdata_o always shows the current register value, which is the old value during the exchange cycle.
- R10: An exchange has priority: a shift or a qualified decrement falling in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cyc_en_i | input | 1 | Instruction-cycle enable |
| cyc_phase_i | input | 1 | Instruction-cycle clock waveform gated onto sk_o |
| mode_ld_i | input | 1 | Load strobe for the mode register |
| mode_wdata_i | input | 2 | Mode value: bit 0 count mode, bit 1 output enable |
| si_i | input | 1 | Serial data or event input |
| xchg_i | input | 1 | Exchange request |
| xchg_wdata_i | input | WIDTH | Value swapped into the register |
| carry_i | input | 1 | Carry bit copied to the clock-control latch on exchange |
| xchg_rdata_o | output | WIDTH | Current register contents |
| so_o | output | 1 | Serial output |
| sk_o | output | 1 | Serial clock output |

## Verification
The bench builds the block with WIDTH = 4 and LOW_SAMPLES = 2. A 4-bit register makes the wrap from 0 to 15 reachable with a few pulses. A two-sample low window keeps a pulse that is too short (a single low sample) and a qualified pulse only one cycle apart. That makes it cheap to land a qualified decrement on the same cycle as an exchange. Together with a long mixed random phase, these settings drive mode changes in the middle of a pulse and exchanges across both modes against the reference model.

// File: rtl/sio_pkg.sv
package sio_pkg;

  // Mode register layout: bit 0 count mode, bit 1 output enable
  typedef struct packed {
    logic oe;
    logic cnt;
  } sio_mode_t;

endpackage

// File: rtl/sio_low_filter.sv
module sio_low_filter #(
  parameter int LOW_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic si,
  output logic dec_pulse
);

  localparam int CW = (LOW_SAMPLES < 2) ? 1 : $clog2(LOW_SAMPLES);
  localparam logic [CW-1:0] LAST = CW'(LOW_SAMPLES - 1);

  logic          armed_q, armed_d;
  logic [CW-1:0] low_q, low_d;
  logic          hit;

  // Last required low sample of an armed pulse
  assign hit       = cyc_en && armed_q && !si && (low_q == LAST);
  assign dec_pulse = hit;

  always_comb begin
    armed_d = armed_q;
    low_d   = low_q;
    if (cyc_en) begin
      if (si) begin
        armed_d = 1'b1;
        low_d   = '0;
      end else if (armed_q) begin
        if (hit) begin
          armed_d = 1'b0;
          low_d   = '0;
        end else begin
          low_d = low_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      low_q   <= '0;
    end else begin
      armed_q <= armed_d;
      low_q   <= low_d;
    end
  end

endmodule

// File: rtl/sio_core.sv
module sio_core #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             cnt_mode,
  input  logic             si,
  input  logic             dec_pulse,
  input  logic             xchg,
  input  logic [WIDTH-1:0] xchg_wdata,
  input  logic             carry,
  output logic [WIDTH-1:0] q,
  output logic             skl
);

  logic [WIDTH-1:0] q_r, q_d;
  logic             skl_r, skl_d;

  always_comb begin
    q_d   = q_r;
    skl_d = skl_r;
    if (cyc_en && xchg) begin
      q_d   = xchg_wdata;
      skl_d = carry;
    end else if (cyc_en && !cnt_mode) begin
      q_d = {q_r[WIDTH-2:0], si};
    end else if (cnt_mode && dec_pulse) begin
      q_d = q_r - WIDTH'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= '0;
      skl_r <= 1'b1;
    end else begin
      q_r   <= q_d;
      skl_r <= skl_d;
    end
  end

  assign q   = q_r;
  assign skl = skl_r;

endmodule

// File: rtl/sio_pins.sv
module sio_pins #(
  parameter int WIDTH = 4
) (
  input  logic               msb,
  input  sio_pkg::sio_mode_t mode,
  input  logic               skl,
  input  logic               cyc_phase,
  output logic               so,
  output logic               sk
);

  always_comb begin
    if (mode.cnt) begin
      so = mode.oe;
      sk = skl;
    end else begin
      so = mode.oe & msb;
      sk = skl & cyc_phase;
    end
  end

endmodule

// File: rtl/sio_dual_reg.sv
module sio_dual_reg #(
  parameter int WIDTH       = 4,
  parameter int LOW_SAMPLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en_i,
  input  logic             cyc_phase_i,
  input  logic             mode_ld_i,
  input  logic [1:0]       mode_wdata_i,
  input  logic             si_i,
  input  logic             xchg_i,
  input  logic [WIDTH-1:0] xchg_wdata_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] xchg_rdata_o,
  output logic             so_o,
  output logic             sk_o
);

  import sio_pkg::*;

  logic             rst_meta_q, rst_sync_n;
  sio_mode_t        mode_r;
  logic             dec_pulse;
  logic [WIDTH-1:0] q;
  logic             skl;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_r <= '0;
    end else if (mode_ld_i) begin
      mode_r <= sio_mode_t'(mode_wdata_i);
    end
  end

  sio_low_filter #(.LOW_SAMPLES(LOW_SAMPLES)) u_filt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .cyc_en    (cyc_en_i),
    .si        (si_i),
    .dec_pulse (dec_pulse)
  );

  sio_core #(.WIDTH(WIDTH)) u_core (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cyc_en     (cyc_en_i),
    .cnt_mode   (mode_r.cnt),
    .si         (si_i),
    .dec_pulse  (dec_pulse),
    .xchg       (xchg_i),
    .xchg_wdata (xchg_wdata_i),
    .carry      (carry_i),
    .q          (q),
    .skl        (skl)
  );

  sio_pins #(.WIDTH(WIDTH)) u_pins (
    .msb       (q[WIDTH-1]),
    .mode      (mode_r),
    .skl       (skl),
    .cyc_phase (cyc_phase_i),
    .so        (so_o),
    .sk        (sk_o)
  );

  assign xchg_rdata_o = q;

endmodule

// File: rtl/sio_dual_reg_chk.sv
module sio_dual_reg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_en,
  input logic             cyc_phase,
  input logic             cnt_mode,
  input logic             oe,
  input logic             si,
  input logic             xchg,
  input logic [WIDTH-1:0] xchg_wdata,
  input logic             carry,
  input logic             dec,
  input logic [WIDTH-1:0] cur,
  input logic             skl,
  input logic             so,
  input logic             sk
);

  assert_xchg_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && xchg) |=> (cur == $past(xchg_wdata)) && (skl == $past(carry)));

  assert_shift_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_en && !xchg && !cnt_mode) |=> (cur == {$past(cur[WIDTH-2:0]), $past(si)}));

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> $stable(cur) && $stable(skl));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && cnt_mode && !xchg && (cur == '0)) |=> (cur == '1));

  assert_dec_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cyc_en && !si));

  assert_so_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_mode |-> (so == oe));

  assert_sk_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_mode && !cyc_phase) |-> !sk);

endmodule

bind sio_dual_reg sio_dual_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cyc_en     (cyc_en_i),
  .cyc_phase  (cyc_phase_i),
  .cnt_mode   (mode_r.cnt),
  .oe         (mode_r.oe),
  .si         (si_i),
  .xchg       (xchg_i),
  .xchg_wdata (xchg_wdata_i),
  .carry      (carry_i),
  .dec        (dec_pulse),
  .cur        (q),
  .skl        (skl),
  .so         (so_o),
  .sk         (sk_o)
);

// File: tb/test_sio_dual_reg.sv
module test_sio_dual_reg;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 4;
  localparam int LOWS       = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cyc_en, cyc_phase, mode_ld, si, xchg, carry;
  logic [1:0]   mode_w;
  logic [W-1:0] xdata;
  logic [W-1:0] rdata;
  logic         so, sk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model state
  int m_q, m_skl, m_cnt, m_oe, m_armed, m_low;
  string tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_dual_reg #(.WIDTH(W), .LOW_SAMPLES(LOWS)) i_sio_dual_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .cyc_en_i     (cyc_en),
    .cyc_phase_i  (cyc_phase),
    .mode_ld_i    (mode_ld),
    .mode_wdata_i (mode_w),
    .si_i         (si),
    .xchg_i       (xchg),
    .xchg_wdata_i (xdata),
    .carry_i      (carry),
    .xchg_rdata_o (rdata),
    .so_o         (so),
    .sk_o         (sk)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    int e_so, e_sk;
    e_so = m_cnt ? m_oe : (m_oe & ((m_q >> (W-1)) & 1));
    e_sk = m_cnt ? m_skl : (m_skl & int'(cyc_phase));
    chk({tag, " reg"}, int'(rdata), m_q);
    chk({tag, " so"}, int'(so), e_so);
    chk({tag, " sk"}, int'(sk), e_sk);
  endtask

  // one clock: compare, drive, advance model for the coming edge
  task automatic tick(input bit en, input bit ph, input bit ld, input int mw,
                      input bit s, input bit xv, input int xd, input bit cy);
    bit dec;
    @(negedge clk);
    compare_model();
    cyc_en = en; cyc_phase = ph; mode_ld = ld; mode_w = 2'(mw);
    si = s; xchg = xv; xdata = W'(xd); carry = cy;
    dec = 0;
    if (en) begin
      if (s) begin
        m_armed = 1; m_low = 0;
      end else if (m_armed != 0) begin
        m_low++;
        if (m_low == LOWS) begin
          dec = 1; m_armed = 0; m_low = 0;
        end
      end
    end
    if (en && xv) begin
      m_q = xd; m_skl = cy;
    end else if (en && m_cnt == 0) begin
      m_q = ((m_q << 1) | int'(s)) % (1 << W);
    end else if (dec && m_cnt != 0) begin
      m_q = (m_q + (1 << W) - 1) % (1 << W);
    end
    if (ld) begin
      m_cnt = mw & 1; m_oe = (mw >> 1) & 1;
    end
  endtask

  task automatic idle(input bit s);
    tick(1'b0, 1'b1, 1'b0, 0, s, 1'b0, 0, 1'b0);
  endtask

  task automatic after_edge();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    rst_n = 1'b0;
    cyc_en = 0; cyc_phase = 1; mode_ld = 0; mode_w = 0; si = 0;
    xchg = 0; xdata = 0; carry = 0;
    m_q = 0; m_skl = 1; m_cnt = 0; m_oe = 0; m_armed = 0; m_low = 0;
    tag = "R1";
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 reg", int'(rdata), 0);
    chk("R1 so", int'(so), 0);
    chk("R1 sk", int'(sk), 1);
    rst_n = 1'b1;
    repeat (3) idle(1'b0);

    // R2, R3, R4: shift mode with output enabled
    tag = "R2";
    tick(1'b0, 1'b1, 1'b1, 2, 1'b0, 1'b0, 0, 1'b0);
    tag = "R3";
    for (int i = 0; i < 40; i++)
      tick(1'($urandom_range(0, 1)), 1'(i % 2), 1'b0, 0,
           1'($urandom_range(0, 1)), 1'b0, 0, 1'b0);
    tag = "R4";
    tick(1'b1, 1'b1, 1'b0, 0, 1'b1, 1'b1, 4'h8, 1'b1);
    after_edge();
    chk("R4 so msb", int'(so), 1);
    tick(1'b0, 1'b1, 1'b1, 0, 1'b0, 1'b0, 0, 1'b0);
    for (int i = 0; i < 12; i++)
      tick(1'b1, 1'(i % 2), 1'b0, 0, 1'($urandom_range(0, 1)), 1'b0, 0, 1'b0);

    // R9, R10: exchanges in shift mode
    tag = "R9";
    for (int i = 0; i < 20; i++)
      tick(1'b1, 1'(i % 2), 1'b0, 0, 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), int'($urandom_range(0, 15)),
           1'($urandom_range(0, 1)));
    tick(1'b1, 1'b1, 1'b0, 0, 1'b1, 1'b1, 4'h5, 1'b0);
    after_edge();
    chk("R9 swap value", int'(rdata), 5);
    chk("R10 shift dropped", int'(rdata), 5);

    // R5, R7, R8: count mode, load 2, carry 0
    tag = "R7";
    tick(1'b1, 1'b1, 1'b1, 3, 1'b1, 1'b1, 2, 1'b0);
    after_edge();
    chk("R8 sk latch level", int'(sk), 0);
    chk("R5 so oe", int'(so), 1);
    for (int p = 0; p < 3; p++) begin
      tick(1'b1, 1'b1, 1'b0, 0, 1'b1, 1'b0, 0, 1'b0);
      tick(1'b1, 1'b1, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0);
      tick(1'b1, 1'b1, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0);
    end
    after_edge();
    chk("R7 wrap to 15", int'(rdata), 15);

    // R6: single low sample ignored, long low counts once
    tag = "R6";
    tick(1'b1, 1'b0, 1'b0, 0, 1'b1, 1'b0, 0, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 0, 1'b1, 1'b0, 0, 1'b0);
    after_edge();
    chk("R6 short pulse", int'(rdata), 15);
    for (int i = 0; i < 6; i++)
      tick(1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0);
    after_edge();
    chk("R6 held low once", int'(rdata), 14);

    // R10: exchange on the qualifying low sample
    tag = "R10";
    tick(1'b1, 1'b0, 1'b0, 0, 1'b1, 1'b0, 0, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0, 0, 1'b0);
    tick(1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b1, 9, 1'b1);
    after_edge();
    chk("R10 decrement dropped", int'(rdata), 9);

    // R5: count mode, output enable clear
    tag = "R5";
    tick(1'b0, 1'b0, 1'b1, 1, 1'b1, 1'b0, 0, 1'b0);
    after_edge();
    chk("R5 so zero", int'(so), 0);

    // R8: mixed random traffic across modes
    tag = "R8";
    for (int i = 0; i < 400; i++)
      tick(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 15) == 0), int'($urandom_range(0, 3)),
           1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 7) == 0),
           int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)));
    @(negedge clk);
    compare_model();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule